// File: doc/BRIEF.md
# Long-Press Dual-Button Reset Controller

This block sits between two active-low push buttons and the system reset net. It raises a reset only when both buttons have been held down together, without a break, for a long setup delay. A shorter press never reaches the reset output, so software can still see each button on its own interrupt line and treat a brief press as a request rather than a reset. All timing comes from one clock divided down to a tick. Every delay is a whole number of ticks, and the setup delay is set in half-second steps of ticks.

One parameter sets how long the pulse lasts. In button-held mode the reset lasts only while both buttons stay down. In fixed-pulse mode the reset lasts a set number of ticks, whatever the buttons do. After a fixed pulse, both buttons must be seen released before a new count can start. A test-request input stands in for the overvoltage detector on the primary button. When it is held long enough, the block latches a test mode, gives a feedback pulse, and from then on uses a much shorter setup delay. An undervoltage input holds the output inactive and clears every counter while it is high. Only the asynchronous reset, which models a power cycle, clears test mode. The output polarity is a parameter.

Top module: `lp_reset_ctrl`

## Requirements
- R1: With one tick per clock, the output asserts on the (SETUP_TICKS+2)-th rising clock edge after both buttons go low and stay low. The setup delay is SETUP_STEPS*TICKS_PER_STEP ticks, and the 2 extra edges are the input synchronizer.
- R2: If either button goes high for one clock or more before the setup delay has elapsed, the count restarts from zero. A new full delay is then needed after both are low again.
- R3: In button-held mode (FIXED_PULSE=0), the output deasserts on the 3rd rising edge after either button goes high, and no minimum pulse width applies.
- R4: In fixed-pulse mode (FIXED_PULSE=1), the output stays asserted for exactly REC_TICKS ticks, whatever the button inputs do.
- R5: In fixed-pulse mode, once the pulse ends, no new setup count begins until both buttons have been seen high together. Buttons that stay held do not retrigger.
- R6: When test_req is high for ENTRY_TICKS ticks without a break, test mode latches and the output asserts as feedback. With one tick per clock, this happens on edge ENTRY_TICKS+2. The feedback lasts REC_TICKS ticks in fixed-pulse mode, or until test_req falls in button-held mode. If test_req drops earlier, the entry count restarts.
- R7: In test mode, a press of both buttons uses TEST_SETUP_TICKS ticks in place of the long setup delay.
- R8: Test mode stays latched through undervoltage and later presses. Only the asynchronous reset rst_n clears it.
- R9: While uv_flag is high, the buttons are ignored, all counters clear and the output is inactive from the 3rd edge on, even if a reset pulse was running. When uv_flag falls, a full new setup delay is needed.
- R10: sys_rst is high when asserted if ACTIVE_HIGH=1 and low when asserted if ACTIVE_HIGH=0. It is inactive during and after reset, and no pulse is produced at power-up.
- R11: With CLK_PER_TICK>1, each delay is counted in ticks of CLK_PER_TICK clocks. The setup delay is then SETUP_TICKS*CLK_PER_TICK clocks, plus synchronizer latency and at most one tick of phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle), released synchronously inside |
| btn_a_n | input | 1 | Primary push button, low when pressed |
| btn_b_n | input | 1 | Secondary push button, low when pressed |
| test_req | input | 1 | Test-entry flag (overvoltage seen on the primary button) |
| uv_flag | input | 1 | Supply undervoltage flag, high forces the output inactive |
| sys_rst | output | 1 | System reset output, polarity set by ACTIVE_HIGH |

## Verification
The bench builds two copies with small tick counts: SETUP_TICKS=20 (4 steps of 5), REC_TICKS=8, ENTRY_TICKS=6 and TEST_SETUP_TICKS=4. The first copy is fixed-pulse, active low, with one tick per clock, so every edge at which the output changes can be predicted exactly from the tick counts. The second copy is button-held, active high, with two clocks per tick. It checks the prescaled delays against a window and checks the release and flag-follow behaviour. Both copies see the same stimulus: a press cut short by a one-clock release, long holds, an undervoltage during a pulse, an aborted and then a completed test entry, test-mode presses before and after an undervoltage, and a final power-cycle reset.

// File: rtl/lprc_pkg.sv
package lprc_pkg;

  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_PULSE = 2'd1,
    ST_WAIT  = 2'd2
  } press_st_t;

  function automatic int unsigned max2(input int unsigned x, input int unsigned y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/lprc_sync.sv
module lprc_sync #(
  parameter int                WIDTH   = 1,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/lprc_tick.sv
module lprc_tick #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_every_clock
      assign tick = 1'b1;
    end else begin : g_divider
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] div_q, div_d;

      always_comb begin
        if (div_q == LAST) div_d = '0;
        else               div_d = div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign tick = (div_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/lprc_press_fsm.sv
module lprc_press_fsm
  import lprc_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SETUP_TICKS = 4000,
  parameter int TEST_TICKS  = 21,
  parameter int REC_TICKS   = 210,
  parameter bit FIXED_PULSE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic both_low,
  input  logic both_high,
  input  logic uv,
  input  logic test_mode,
  output logic in_pulse,
  output logic pulse_next
);

  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_TICKS - 1);
  localparam logic [CW-1:0] TEST_LAST  = CW'(TEST_TICKS - 1);
  localparam logic [CW-1:0] REC_LAST   = CW'(REC_TICKS - 1);

  press_st_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_last;

  assign lim_last = test_mode ? TEST_LAST : SETUP_LAST;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (uv) begin
      st_d  = ST_COUNT;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_COUNT: begin
          if (!both_low) begin
            cnt_d = '0;
          end else if (tick) begin
            if (cnt_q >= lim_last) begin
              st_d  = ST_PULSE;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_PULSE: begin
          if (FIXED_PULSE) begin
            if (tick) begin
              if (cnt_q >= REC_LAST) begin
                st_d  = ST_WAIT;
                cnt_d = '0;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
          end else if (!both_low) begin
            st_d  = ST_COUNT;
            cnt_d = '0;
          end
        end
        ST_WAIT: begin
          cnt_d = '0;
          if (both_high) st_d = ST_COUNT;
        end
        default: begin
          st_d  = ST_COUNT;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_COUNT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign in_pulse   = (st_q == ST_PULSE);
  assign pulse_next = (st_d == ST_PULSE);

endmodule

// File: rtl/lprc_test_ctl.sv
module lprc_test_ctl #(
  parameter int CW          = 16,
  parameter int ENTRY_TICKS = 42,
  parameter int REC_TICKS   = 210,
  parameter bit FIXED_PULSE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flag,
  input  logic uv,
  output logic test_mode,
  output logic fb_next
);

  localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_TICKS - 1);
  localparam logic [CW-1:0] REC_LAST   = CW'(REC_TICKS - 1);

  logic          mode_q, mode_d;
  logic          fb_q, fb_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    mode_d = mode_q;
    fb_d   = fb_q;
    cnt_d  = cnt_q;
    if (uv) begin
      fb_d  = 1'b0;
      cnt_d = '0;
    end else if (!mode_q) begin
      if (!flag) begin
        cnt_d = '0;
      end else if (tick) begin
        if (cnt_q >= ENTRY_LAST) begin
          mode_d = 1'b1;
          fb_d   = 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (fb_q) begin
      if (FIXED_PULSE) begin
        if (tick) begin
          if (cnt_q >= REC_LAST) begin
            fb_d  = 1'b0;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end else if (!flag) begin
        fb_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      fb_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      fb_q   <= fb_d;
      cnt_q  <= cnt_d;
    end
  end

  assign test_mode = mode_q;
  assign fb_next   = fb_d;

endmodule

// File: rtl/lp_reset_ctrl.sv
module lp_reset_ctrl
  import lprc_pkg::*;
#(
  parameter int CLK_PER_TICK     = 100000,
  parameter int TICKS_PER_STEP   = 500,
  parameter int SETUP_STEPS      = 8,
  parameter int REC_TICKS        = 210,
  parameter int ENTRY_TICKS      = 42,
  parameter int TEST_SETUP_TICKS = 21,
  parameter bit FIXED_PULSE      = 1'b1,
  parameter bit ACTIVE_HIGH      = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_a_n,
  input  logic btn_b_n,
  input  logic test_req,
  input  logic uv_flag,
  output logic sys_rst
);

  localparam int SETUP_TICKS = SETUP_STEPS * TICKS_PER_STEP;
  localparam int MAX_TICKS   = int'(max2(max2(SETUP_TICKS, REC_TICKS),
                                         max2(ENTRY_TICKS, TEST_SETUP_TICKS)));
  localparam int CW          = $clog2(MAX_TICKS + 1);

  logic       core_rst_n;
  logic [3:0] in_s;
  logic       a_s, b_s, test_s, uv_s;
  logic       tick;
  logic       both_low, both_high;
  logic       test_mode, fb_next;
  logic       in_pulse, pulse_next;
  logic       asserted_q, asserted_d;

  lprc_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(core_rst_n)
  );

  lprc_sync #(.WIDTH(4), .STAGES(2), .RST_VAL(4'b0011)) u_in_sync (
    .clk(clk), .arst_n(core_rst_n),
    .d({uv_flag, test_req, btn_b_n, btn_a_n}), .q(in_s)
  );

  assign a_s       = in_s[0];
  assign b_s       = in_s[1];
  assign test_s    = in_s[2];
  assign uv_s      = in_s[3];
  assign both_low  = ~a_s & ~b_s;
  assign both_high = a_s & b_s;

  lprc_tick #(.DIV(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(core_rst_n), .tick(tick)
  );

  lprc_test_ctl #(
    .CW(CW), .ENTRY_TICKS(ENTRY_TICKS), .REC_TICKS(REC_TICKS),
    .FIXED_PULSE(FIXED_PULSE)
  ) u_test (
    .clk(clk), .rst_n(core_rst_n), .tick(tick), .flag(test_s), .uv(uv_s),
    .test_mode(test_mode), .fb_next(fb_next)
  );

  lprc_press_fsm #(
    .CW(CW), .SETUP_TICKS(SETUP_TICKS), .TEST_TICKS(TEST_SETUP_TICKS),
    .REC_TICKS(REC_TICKS), .FIXED_PULSE(FIXED_PULSE)
  ) u_press (
    .clk(clk), .rst_n(core_rst_n), .tick(tick), .both_low(both_low),
    .both_high(both_high), .uv(uv_s), .test_mode(test_mode),
    .in_pulse(in_pulse), .pulse_next(pulse_next)
  );

  assign asserted_d = (pulse_next | fb_next) & ~uv_s;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) asserted_q <= 1'b0;
    else             asserted_q <= asserted_d;
  end

  generate
    if (ACTIVE_HIGH) begin : g_out_high
      assign sys_rst = asserted_q;
    end else begin : g_out_low
      assign sys_rst = ~asserted_q;
    end
  endgenerate

endmodule

// File: rtl/lprc_checker.sv
module lprc_checker #(
  parameter int CW          = 16,
  parameter int SETUP_TICKS = 4000,
  parameter int TEST_TICKS  = 21,
  parameter int REC_TICKS   = 210,
  parameter bit FIXED_PULSE = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic a_s,
  input logic b_s,
  input logic uv_s,
  input logic test_mode,
  input logic in_pulse,
  input logic asserted_q
);

  logic [CW:0] run_q;
  logic [CW:0] lim;

  assign lim = test_mode ? (CW+1)'(TEST_TICKS) : (CW+1)'(SETUP_TICKS);

  // ticks counted with both buttons held since the last break
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_q <= '0;
    else if (a_s || b_s || uv_s) run_q <= '0;
    else if (tick && run_q != '1) run_q <= run_q + 1'b1;
  end

  p_setup_met_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_pulse) |-> (run_q >= lim));

  p_uv_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uv_s |=> !asserted_q);

  p_test_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> test_mode);

  generate
    if (FIXED_PULSE) begin : g_fixed
      logic [CW:0] plen_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         plen_q <= '0;
        else if (!in_pulse) plen_q <= '0;
        else if (tick)      plen_q <= plen_q + 1'b1;
      end
      p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_pulse |-> (plen_q < (CW+1)'(REC_TICKS)));
    end else begin : g_held
      p_held_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pulse && (a_s || b_s)) |=> !in_pulse);
    end
  endgenerate

endmodule

bind lp_reset_ctrl lprc_checker #(
  .CW(CW), .SETUP_TICKS(SETUP_TICKS), .TEST_TICKS(TEST_SETUP_TICKS),
  .REC_TICKS(REC_TICKS), .FIXED_PULSE(FIXED_PULSE)
) u_chk (
  .clk(clk), .rst_n(core_rst_n), .tick(tick), .a_s(a_s), .b_s(b_s),
  .uv_s(uv_s), .test_mode(test_mode), .in_pulse(in_pulse),
  .asserted_q(asserted_q)
);

// File: tb/lp_reset_ctrl_test.sv
`timescale 1ns/1ps
module lp_reset_ctrl_test;

  localparam int SETUP = 20;
  localparam int REC   = 8;
  localparam int ENTRY = 6;
  localparam int TSET  = 4;
  localparam int DIVP  = 2;

  logic clk = 1'b0;
  logic rst_n, a_n, b_n, treq, uv;
  logic rst_f, rst_p;

  int checks = 0, failures = 0;
  int fu, lu, fp, lp;
  bit done = 0;

  always #4 clk = ~clk;

  lp_reset_ctrl #(
    .CLK_PER_TICK(1), .TICKS_PER_STEP(5), .SETUP_STEPS(4), .REC_TICKS(REC),
    .ENTRY_TICKS(ENTRY), .TEST_SETUP_TICKS(TSET), .FIXED_PULSE(1'b1),
    .ACTIVE_HIGH(1'b0)
  ) uut (
    .clk(clk), .rst_n(rst_n), .btn_a_n(a_n), .btn_b_n(b_n),
    .test_req(treq), .uv_flag(uv), .sys_rst(rst_f)
  );

  lp_reset_ctrl #(
    .CLK_PER_TICK(DIVP), .TICKS_PER_STEP(5), .SETUP_STEPS(4), .REC_TICKS(REC),
    .ENTRY_TICKS(ENTRY), .TEST_SETUP_TICKS(TSET), .FIXED_PULSE(1'b0),
    .ACTIVE_HIGH(1'b1)
  ) uut_push (
    .clk(clk), .rst_n(rst_n), .btn_a_n(a_n), .btn_b_n(b_n),
    .test_req(treq), .uv_flag(uv), .sys_rst(rst_p)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // advance n edges; record first/last edge index where each copy is asserted
  task automatic run(input int n);
    fu = -1; lu = -1; fp = -1; lp = -1;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (rst_f == 1'b0) begin if (fu < 0) fu = k; lu = k; end
      if (rst_p == 1'b1) begin if (fp < 0) fp = k; lp = k; end
    end
  endtask

  initial begin
    rst_n = 1'b0; a_n = 1'b1; b_n = 1'b1; treq = 1'b0; uv = 1'b0;
    repeat (4) @(negedge clk);
    chk_eq("R10 low-polarity inactive in reset", rst_f, 1);
    chk_eq("R10 high-polarity inactive in reset", rst_p, 0);
    rst_n = 1'b1;
    run(5);
    chk_eq("R10 no pulse after power-up (low)", fu, -1);
    chk_eq("R10 no pulse after power-up (high)", fp, -1);

    // R2: short press, one-clock break, then full hold
    a_n = 1'b0; b_n = 1'b0;
    run(15);
    chk_eq("R2 short press ignored", fu, -1);
    b_n = 1'b1; run(1); b_n = 1'b0;
    run(60);
    chk_eq("R1 R2 assert edge after restart", fu, SETUP + 2);
    chk_eq("R4 fixed pulse last edge", lu, SETUP + 2 + REC - 1);
    chk_rng("R11 prescaled setup delay", fp, DIVP*SETUP + 1, DIVP*SETUP + 5);
    chk_eq("R3 held pulse stays while pressed", lp, 60);

    // R3: releasing one button ends held pulse on edge 3
    a_n = 1'b1;
    run(5);
    chk_eq("R3 release deasserts at edge 3", lp, 2);
    chk_eq("R5 no retrigger while held", fu, -1);

    // R5: full release re-arms
    b_n = 1'b1; run(4);
    a_n = 1'b0; b_n = 1'b0;
    run(60);
    chk_eq("R5 re-armed after release", fu, SETUP + 2);
    chk_eq("R4 fixed pulse length", lu - fu + 1, REC);
    chk_rng("R11 prescaled setup again", fp, DIVP*SETUP + 1, DIVP*SETUP + 5);

    // R9: undervoltage during held pulse
    uv = 1'b1;
    run(40);
    chk_eq("R9 uv forces inactive by edge 3", lp, 2);
    chk_eq("R9 buttons ignored under uv", fu, -1);
    uv = 1'b0;
    run(60);
    chk_eq("R9 counters cleared, full delay after uv", fu, SETUP + 2);
    chk_rng("R9 held copy full delay after uv", fp, DIVP*SETUP + 1, DIVP*SETUP + 5);

    // R6: aborted then completed test entry
    a_n = 1'b1; b_n = 1'b1; run(10);
    treq = 1'b1; run(4); treq = 1'b0;
    run(10);
    chk_eq("R6 short test flag no feedback (low)", fu, -1);
    chk_eq("R6 short test flag no feedback (high)", fp, -1);
    treq = 1'b1;
    run(30);
    chk_eq("R6 feedback assert edge", fu, ENTRY + 2);
    chk_eq("R6 fixed feedback length", lu - fu + 1, REC);
    chk_rng("R6 held feedback start", fp, DIVP*ENTRY + 1, DIVP*ENTRY + 5);
    chk_eq("R6 held feedback follows flag", lp, 30);
    treq = 1'b0;
    run(5);
    chk_eq("R6 held feedback ends with flag", lp, 2);

    // R7: short setup in test mode
    a_n = 1'b0; b_n = 1'b0;
    run(20);
    chk_eq("R7 test-mode setup edge", fu, TSET + 2);
    chk_eq("R7 test-mode fixed length", lu - fu + 1, REC);
    chk_rng("R7 held copy test-mode setup", fp, DIVP*TSET + 1, DIVP*TSET + 5);

    // R8: survives uv
    a_n = 1'b1; b_n = 1'b1; run(10);
    uv = 1'b1; run(5); uv = 1'b0; run(5);
    a_n = 1'b0; b_n = 1'b0;
    run(20);
    chk_eq("R8 test mode kept after uv", fu, TSET + 2);

    // R8: power cycle clears test mode
    a_n = 1'b1; b_n = 1'b1; run(4);
    rst_n = 1'b0; run(3);
    chk_eq("R10 inactive during reset", rst_f, 1);
    rst_n = 1'b1; run(5);
    a_n = 1'b0; b_n = 1'b0;
    run(30);
    chk_eq("R8 reset leaves test mode", fu, SETUP + 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule